// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block gathers a set of device interrupt lines, organised as banks of 32 sources, and presents them to a processor as one interrupt request plus a small register window. Each source is either edge-sensitive or level-sensitive. A fixed per-bank mask parameter makes that choice. An edge source latches a rising edge into an event register, and software clears it by writing ones to an acknowledge register. A level source is never latched. While its line is high and the source is enabled, it requests service directly.

Software programs a per-bank enable register and can read the live state of every line. It can also read a status word that names the highest-numbered pending source. Source lines are synchronised through two flip-flops before any use. A line that is already high when its enable bit is set does not produce an event. Only a fresh rising edge does.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Byte addresses, with accesses only at word-aligned addresses. Bank b has its register group at 0x10*(NUM_BANKS-b). With two banks, bank 0 is at 0x20 and bank 1 is at 0x10. Inside a group the word offsets are: 0x0 event, 0x4 enable, 0x8 acknowledge (reads 0), 0xC live level. The status word is at 0x00. Any other address reads 0. Writes to the event, level and status addresses have no effect.
- R2: After a synchronous reset, all event and enable bits are 0, the interrupt output is low and the status word reads 0.
- R3: An edge-sensitive source sets its event bit on a rising edge of its synchronised line, but only while it is enabled. The bit becomes visible after the third rising clock edge following the input change. It stays set until acknowledged. An edge that arrives while the source is disabled is not recorded.
- R4: Writing 1 to an acknowledge bit clears the matching event bit, and writing 0 leaves it unchanged. If an acknowledge and a newly detected edge land on the same clock, the event bit stays set.
- R5: The level register returns the synchronised, unlatched state of every source line in the bank, for both edge and level sources. A change shows after the second rising edge.
- R6: The per-bank parameter mask marks the level-sensitive sources. These never set an event bit, and they request service while their synchronised line is high. The default marks bits 20..29 of bank 0 and no bits of bank 1, so bit 22 of bank 1 (source 54) is edge-sensitive.
- R7: Enabling a source whose line is already high creates no event and no request for an edge source.
- R8: A bank's pending vector is (event | (level & levelMask)) & enable. The interrupt output is high exactly when any bank has a pending bit.
- R9: In the status word, bit 6 is a valid flag and bits 5:0 give the number of the highest-numbered pending source, where source n is bank n/32, bit n%32. The upper bank is scanned before the lower bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srcIn | input | 64 | Raw source lines, source n on bit n |
| busAddr | input | 6 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from the address |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the bus only decodes word-aligned group addresses. They also assume that the source lines are quiet or stable for the whole reset period, so that the first cycle after reset starts from cleared registers. The stimulus meets these assumptions. It changes the source lines and the bus signals four nanoseconds after a rising edge and holds every write strobe for exactly one edge. Each source edge is spaced at least three clocks from the next, so every edge passes through the synchroniser before the bench checks the event register.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_EVENT,
    RD_ENABLE,
    RD_ACK,
    RD_LEVEL
  } regSel_e;

  typedef struct packed {
    logic    enableWr;
    logic    ackWr;
    logic [3:0] bankIdx;
    regSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/irq_bank_slice.sv
module irq_bank_slice #(
  parameter int BANK_W = 32,
  parameter logic [BANK_W-1:0] LEVEL_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] srcIn,
  input  logic              enableWr,
  input  logic              ackWr,
  input  logic [BANK_W-1:0] wrData,
  output logic [BANK_W-1:0] eventQ,
  output logic [BANK_W-1:0] enableQ,
  output logic [BANK_W-1:0] levelLive,
  output logic [BANK_W-1:0] pending
);

  localparam logic [BANK_W-1:0] EDGE_MASK = ~LEVEL_MASK;

  logic [BANK_W-1:0] syncA;
  logic [BANK_W-1:0] syncB;
  logic [BANK_W-1:0] lastB;
  logic [BANK_W-1:0] riseVec;
  logic [BANK_W-1:0] ackClr;

  // two-stage synchroniser plus previous-value stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      syncA <= '0;
      syncB <= '0;
      lastB <= '0;
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      lastB <= syncB;
    end
  end

  // a rise on an edge source is recorded only while enabled
  assign riseVec = syncB & ~lastB & enableQ & EDGE_MASK;
  assign ackClr  = ackWr ? wrData : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      eventQ  <= '0;
      enableQ <= '0;
    end else begin
      eventQ <= (eventQ & ~ackClr) | riseVec;
      if (enableWr) begin
        enableQ <= wrData;
      end
    end
  end

  assign levelLive = syncB;
  assign pending   = (eventQ | (syncB & LEVEL_MASK)) & enableQ;

endmodule

// File: rtl/irq_bank_control.sv
module irq_bank_control
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6,
  localparam int NUM_SRC   = NUM_BANKS * BANK_W,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [NUM_SRC-1:0]   pendingAll,
  output busStrobe_t           strobe,
  output logic                 statusValid,
  output logic [SRC_IDX_W-1:0] statusNum
);

  localparam int GRP_W  = ADDR_W - 4;
  localparam int BIT_IW = $clog2(BANK_W);

  logic [GRP_W-1:0] grp;
  logic [1:0]       off;
  logic             aligned;

  assign grp     = addr[ADDR_W-1:4];
  assign off     = addr[3:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = RD_NONE;
    if (aligned) begin
      if (grp == '0 && off == 2'd0) begin
        strobe.rdSel = RD_STATUS;
      end else if (grp >= GRP_W'(1) && grp <= GRP_W'(NUM_BANKS)) begin
        strobe.bankIdx = 4'(NUM_BANKS) - 4'(grp);
        case (off)
          2'd0:    strobe.rdSel = RD_EVENT;
          2'd1:    strobe.rdSel = RD_ENABLE;
          2'd2:    strobe.rdSel = RD_ACK;
          default: strobe.rdSel = RD_LEVEL;
        endcase
        strobe.enableWr = wrEn && (off == 2'd1);
        strobe.ackWr    = wrEn && (off == 2'd2);
      end
    end
  end

  // per-bank highest-bit search, then upper banks override lower ones
  logic [NUM_BANKS-1:0] bankHit;
  logic [BIT_IW-1:0]    bankBit [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_enc
    always_comb begin
      bankHit[b] = 1'b0;
      bankBit[b] = '0;
      for (int i = 0; i < BANK_W; i++) begin
        if (pendingAll[b*BANK_W + i]) begin
          bankHit[b] = 1'b1;
          bankBit[b] = BIT_IW'(i);
        end
      end
    end
  end

  always_comb begin
    statusValid = 1'b0;
    statusNum   = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bankHit[b]) begin
        statusValid = 1'b1;
        statusNum   = SRC_IDX_W'(b * BANK_W) + SRC_IDX_W'(bankBit[b]);
      end
    end
  end

endmodule

// File: rtl/irq_bank_datapath.sv
module irq_bank_datapath
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = '0,
  localparam int NUM_SRC   = NUM_BANKS * BANK_W,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   srcIn,
  input  logic [BANK_W-1:0]    wrData,
  input  busStrobe_t           strobe,
  input  logic                 statusValid,
  input  logic [SRC_IDX_W-1:0] statusNum,
  output logic [BANK_W-1:0]    rdData,
  output logic [NUM_SRC-1:0]   eventAll,
  output logic [NUM_SRC-1:0]   enableAll,
  output logic [NUM_SRC-1:0]   pendingAll,
  output logic                 irqOut
);

  logic [NUM_SRC-1:0] levelAll;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankSel;
    assign bankSel = (strobe.bankIdx == 4'(b));

    irq_bank_slice #(
      .BANK_W     (BANK_W),
      .LEVEL_MASK (LEVEL_MASK[b*BANK_W +: BANK_W])
    ) u_slice (
      .clk       (clk),
      .rst       (rst),
      .srcIn     (srcIn[b*BANK_W +: BANK_W]),
      .enableWr  (strobe.enableWr && bankSel),
      .ackWr     (strobe.ackWr && bankSel),
      .wrData    (wrData),
      .eventQ    (eventAll[b*BANK_W +: BANK_W]),
      .enableQ   (enableAll[b*BANK_W +: BANK_W]),
      .levelLive (levelAll[b*BANK_W +: BANK_W]),
      .pending   (pendingAll[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rdData = '0;
    case (strobe.rdSel)
      RD_STATUS: begin
        rdData[SRC_IDX_W]     = statusValid;
        rdData[SRC_IDX_W-1:0] = statusNum;
      end
      RD_EVENT, RD_ENABLE, RD_LEVEL: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (strobe.bankIdx == 4'(b)) begin
            if (strobe.rdSel == RD_EVENT)       rdData = eventAll[b*BANK_W +: BANK_W];
            else if (strobe.rdSel == RD_ENABLE) rdData = enableAll[b*BANK_W +: BANK_W];
            else                                rdData = levelAll[b*BANK_W +: BANK_W];
          end
        end
      end
      default: rdData = '0;
    endcase
  end

  assign irqOut = |pendingAll;

endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 6,
  parameter logic [NUM_BANKS*BANK_W-1:0] LEVEL_MASK = {32'h0000_0000, 32'h3ff0_0000},
  localparam int NUM_SRC   = NUM_BANKS * BANK_W,
  localparam int SRC_IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic [BANK_W-1:0]  busWrData,
  output logic [BANK_W-1:0]  busRdData,
  output logic               irqOut
);

  busStrobe_t           strobe;
  logic                 statusValid;
  logic [SRC_IDX_W-1:0] statusNum;
  logic [NUM_SRC-1:0]   eventAll;
  logic [NUM_SRC-1:0]   enableAll;
  logic [NUM_SRC-1:0]   pendingAll;

  irq_bank_control #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W)
  ) u_control (
    .addr        (busAddr),
    .wrEn        (busWrEn),
    .pendingAll  (pendingAll),
    .strobe      (strobe),
    .statusValid (statusValid),
    .statusNum   (statusNum)
  );

  irq_bank_datapath #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .srcIn       (srcIn),
    .wrData      (busWrData),
    .strobe      (strobe),
    .statusValid (statusValid),
    .statusNum   (statusNum),
    .rdData      (busRdData),
    .eventAll    (eventAll),
    .enableAll   (enableAll),
    .pendingAll  (pendingAll),
    .irqOut      (irqOut)
  );

endmodule

// File: rtl/banked_irq_ctrl_chk.sv
module banked_irq_ctrl_chk #(
  parameter int NUM_SRC   = 64,
  parameter int SRC_IDX_W = 6,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 irqOut,
  input logic                 statusValid,
  input logic [SRC_IDX_W-1:0] statusNum,
  input logic [NUM_SRC-1:0]   eventAll,
  input logic [NUM_SRC-1:0]   enableAll,
  input logic [NUM_SRC-1:0]   pendingAll
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (eventAll == '0 && enableAll == '0)); // R2

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((eventAll & ~$past(eventAll)) & ~$past(enableAll)) == '0); // R3

  AST_LEVEL_NOT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    (eventAll & LEVEL_MASK) == '0); // R6

  AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (rst)
    irqOut == statusValid); // R8

  AST_STATUS_HIGHEST: assert property (@(posedge clk) disable iff (rst)
    statusValid |-> ((pendingAll >> statusNum) == NUM_SRC'(1))); // R9

endmodule

bind banked_irq_ctrl banked_irq_ctrl_chk #(
  .NUM_SRC    (NUM_SRC),
  .SRC_IDX_W  (SRC_IDX_W),
  .LEVEL_MASK (LEVEL_MASK)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .irqOut      (irqOut),
  .statusValid (statusValid),
  .statusNum   (statusNum),
  .eventAll    (eventAll),
  .enableAll   (enableAll),
  .pendingAll  (pendingAll)
);

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;

  localparam logic [63:0] LEVEL_ALL = 64'h0000_0000_3ff0_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] srcIn = '0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        irqOut;

  always #5 clk = ~clk;

  banked_irq_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .srcIn     (srcIn),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut)
  );

  int checks = 0;
  int fails  = 0;
  bit modelOn = 1'b0;

  // behavioural reference state, flat over all 64 sources
  logic [63:0] mIn1 = '0, mIn2 = '0, mOld = '0, mEvent = '0, mEnable = '0;

  function automatic void decodeAddr(input logic [5:0] a, output int kind, output int bank);
    kind = -1;
    bank = 0;
    if (a[1:0] == 2'b00) begin
      if (a[5:4] == 2'd0 && a[3:2] == 2'd0) kind = 4;
      else if (a[5:4] >= 2'd1 && a[5:4] <= 2'd2) begin
        bank = 2 - int'(a[5:4]);
        kind = int'(a[3:2]);
      end
    end
  endfunction

  function automatic logic [63:0] modelPending();
    return (mEvent | (mIn2 & LEVEL_ALL)) & mEnable;
  endfunction

  function automatic logic [31:0] modelStatus();
    logic [63:0] p;
    p = modelPending();
    for (int i = 63; i >= 0; i--) begin
      if (p[i]) return 32'h40 | 32'(i);
    end
    return 32'h0;
  endfunction

  function automatic logic [31:0] modelRead(input logic [5:0] a);
    int kind, bank;
    decodeAddr(a, kind, bank);
    case (kind)
      0: return mEvent[bank*32 +: 32];
      1: return mEnable[bank*32 +: 32];
      3: return mIn2[bank*32 +: 32];
      4: return modelStatus();
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int kind, bank;
    logic [63:0] clr, rise;
    if (rst) begin
      mIn1 = '0; mIn2 = '0; mOld = '0; mEvent = '0; mEnable = '0;
    end else begin
      clr  = '0;
      rise = mIn2 & ~mOld & mEnable & ~LEVEL_ALL;
      decodeAddr(busAddr, kind, bank);
      if (busWrEn && kind == 1) mEnable[bank*32 +: 32] = busWrData;
      if (busWrEn && kind == 2) clr[bank*32 +: 32] = busWrData;
      mEvent = (mEvent & ~clr) | rise;
      mOld = mIn2;
      mIn2 = mIn1;
      mIn1 = srcIn;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
    if (modelOn) begin
      check(32'(irqOut), 32'(|modelPending()), "R8 per-cycle interrupt output");
      check(busRdData, modelRead(busAddr), "R1 per-cycle register read");
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expectRead(input logic [5:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(busRdData, exp, tag);
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [31:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    tick();
    busWrEn   = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stimulus
    ticks(3);
    modelOn = 1'b1;
    rst = 1'b0;
    tick();
    expectRead(6'h00, 32'h0, "R2 status after reset");
    expectRead(6'h24, 32'h0, "R2 bank0 enable after reset");
    expectRead(6'h14, 32'h0, "R2 bank1 enable after reset");
    check(32'(irqOut), 32'h0, "R2 interrupt low after reset");

    // edge while disabled, live level visible
    srcIn[3] = 1'b1;
    ticks(4);
    expectRead(6'h20, 32'h0, "R3 edge while disabled not recorded");
    expectRead(6'h2C, 32'h8, "R5 live level shows line 3");

    // enabling with the line already high
    writeReg(6'h24, 32'hFFFF_FFFF);
    ticks(3);
    expectRead(6'h20, 32'h0, "R7 enable with line high gives no event");
    check(32'(irqOut), 32'h0, "R7 no request after enable");

    // fresh edge
    srcIn[3] = 1'b0;
    ticks(3);
    srcIn[3] = 1'b1;
    ticks(3);
    expectRead(6'h20, 32'h8, "R3 rising edge latched");
    check(32'(irqOut), 32'h1, "R8 request raised");
    expectRead(6'h00, 32'h43, "R9 status names source 3");
    srcIn[3] = 1'b0;

    // level source 22 in bank 0
    srcIn[22] = 1'b1;
    ticks(2);
    expectRead(6'h00, 32'h56, "R6 level source 22 pending");
    expectRead(6'h20, 32'h8, "R6 level source not latched");
    srcIn[22] = 1'b0;
    ticks(2);
    expectRead(6'h00, 32'h43, "R6 level request drops with line");

    // acknowledge
    writeReg(6'h28, 32'h0);
    expectRead(6'h20, 32'h8, "R4 zero acknowledge leaves event");
    writeReg(6'h28, 32'h8);
    expectRead(6'h20, 32'h0, "R4 acknowledge clears event");
    check(32'(irqOut), 32'h0, "R8 request gone after acknowledge");
    expectRead(6'h28, 32'h0, "R1 acknowledge reads zero");

    // ignored writes
    writeReg(6'h20, 32'hFFFF_FFFF);
    expectRead(6'h20, 32'h0, "R1 event write ignored");
    writeReg(6'h2C, 32'hFFFF_FFFF);
    writeReg(6'h00, 32'hFFFF_FFFF);
    expectRead(6'h00, 32'h0, "R1 status write ignored");

    // upper bank scanned first
    writeReg(6'h14, 32'h20);
    srcIn[3]  = 1'b1;
    srcIn[37] = 1'b1;
    ticks(3);
    expectRead(6'h10, 32'h20, "R3 bank1 source 37 latched");
    expectRead(6'h20, 32'h8, "R3 bank0 source 3 latched");
    expectRead(6'h00, 32'h65, "R9 upper bank wins");

    // acknowledge and new edge on the same clock
    writeReg(6'h28, 32'h8);
    expectRead(6'h20, 32'h0, "R4 cleared before retest");
    srcIn[3] = 1'b0;
    ticks(3);
    srcIn[3] = 1'b1;
    ticks(2);
    writeReg(6'h28, 32'h8);
    expectRead(6'h20, 32'h8, "R4 new edge wins over acknowledge");

    // bank1 bit 22 is edge-sensitive
    writeReg(6'h14, 32'h0040_0020);
    srcIn[54] = 1'b1;
    ticks(3);
    expectRead(6'h10, 32'h0040_0020, "R6 bank1 bit22 latched as edge");
    expectRead(6'h00, 32'h76, "R9 status names source 54");
    srcIn[54] = 1'b0;
    ticks(3);
    expectRead(6'h00, 32'h76, "R3 event held after line falls");

    // mask everything
    writeReg(6'h24, 32'h0);
    writeReg(6'h14, 32'h0);
    check(32'(irqOut), 32'h0, "R8 all enables zero masks request");
    expectRead(6'h00, 32'h0, "R9 status invalid when masked");
    expectRead(6'h20, 32'h8, "R8 events kept while masked");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule